// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block sits between a processor register bus and a successive-approximation converter core. Software writes one control word. That single write picks an input channel, an averaging exponent and the reference source, enables the block and launches the conversion. The sequencer then requests samples from the converter and paces the requests with a programmable gap. It sums the returned 10-bit results and publishes their average. When the average is ready it raises an interrupt. Software clears the interrupt by reading the average register, and needs no separate acknowledge write.

The register slave is word addressed with a 5-bit address. The map is as follows:
- 0: control word.
- 1: converter clock divider, 8 bits, presented on `cnv_clk_div`.
- 2: scan-gap low half.
- 3: scan-gap high half.
- 4: average result.
- 8 to 15: per-channel control registers, 16 bits each.
- 16 to 23: per-channel last-sample registers, read only.

Unmapped addresses read zero. Reads have no latency: `bus_rdata` follows `bus_addr` in the same cycle. A read's side effect takes place at the clock edge that ends the cycle in which `bus_rd` is high.

The sequencer has five states. Their transitions are:
- `S_IDLE` goes to `S_REQ` on an accepted start.
- `S_REQ` always goes to `S_WAIT`.
- `S_WAIT` stays until a sample is valid. After the final sample it goes to `S_DONE`. Otherwise it goes to `S_REQ` when the gap is zero and to `S_GAP` when it is not.
- `S_GAP` goes to `S_REQ` after the programmed number of cycles.
- `S_DONE` always goes to `S_IDLE`.
- An abort sends any state to `S_IDLE`.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, every register reads zero, and both `irq` and `cnv_req` are low.
- R2: Control word layout:
  - bit 0 is start and always reads 0.
  - bits 3:1 are the channel.
  - bit 4 is enable.
  - bits 8:5 are the averaging exponent N.
  - bit 9 selects the internal reference when set and the external reference when clear.
  - bit 10 is busy and is read only.
  - The stored fields read back as written.
  - `cnv_vref_int` equals bit 9.
- R3: A conversion with exponent N issues exactly 2^N one-cycle requests on `cnv_req`. The average is the sum of the samples shifted right by N. N=0 gives a single unaveraged sample.
- R4: Results occupy bits 9:0 of the average register and of the data registers. Bits 31:10 of those registers read zero.
- R5: Each accepted sample is written to the data register of the selected channel, at address 16 + channel.
- R6: `irq` rises 2 cycles after the cycle in which the final sample is valid. A read of address 4 clears it at that edge. A new completion in the same cycle takes priority over the clear.
- R7: A control write with the start bit set, made while busy, is ignored completely:
  - the channel and stored fields are unchanged.
  - no extra requests are issued.
  - no other channel's data register changes.
- R8: A start with the enable bit clear stores the fields but issues no request and raises no interrupt.
- R9: Writing zero to the control word aborts any conversion, returns to idle and clears `irq`. The clock, scan-gap and channel-control registers read back what was written, including zero.
- R10: With scan gap G (the high half and the low half joined), a request follows a non-final valid sample G+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears irq on address 4) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Conversion-complete interrupt |
| cnv_req | output | 1 | One-cycle sample request to converter |
| cnv_chan | output | 3 | Channel being converted |
| cnv_vref_int | output | 1 | Internal reference select |
| cnv_clk_div | output | 8 | Converter clock divider setting |
| cnv_valid | input | 1 | Converter sample valid |
| cnv_data | input | 10 | Converter sample |

## Verification
A control write that launches a conversion puts the first `cnv_req` on the port in the next cycle. After a non-final valid sample, the next request arrives G+1 cycles later, and `irq` follows the final valid sample by 2 cycles. The bench's converter model timestamps each request and each valid sample on falling edges. It then compares those timestamps against the expected gap and interrupt latency, rather than polling. Register side effects land at the edge that ends the bus cycle, so the bench samples `irq`, the data registers and the read-back words on the falling edge after each bus transaction. Idle-safety cases (a start while busy, a start without enable, and an abort) are checked after a fixed settling window longer than the converter latency. The bench confirms that the request count and the interrupt stayed put during that window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] A_CLK   = 5'd1;
    localparam logic [ADDR_W-1:0] A_SRLO  = 5'd2;
    localparam logic [ADDR_W-1:0] A_SRHI  = 5'd3;
    localparam logic [ADDR_W-1:0] A_AVG   = 5'd4;
    localparam logic [ADDR_W-1:0] A_CHCTL = 5'd8;
    localparam logic [ADDR_W-1:0] A_DATA  = 5'd16;

    // control word bit positions
    localparam int B_START  = 0;
    localparam int CHAN_LSB = 1;
    localparam int B_EN     = 4;
    localparam int AVG_LSB  = 5;
    localparam int B_VREF   = 9;
    localparam int B_BUSY   = 10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_GAP,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int AVG_W  = 4,
    parameter int CH_W   = 3,
    parameter int GAP_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [CH_W-1:0]   start_chan,
    input  logic [AVG_W-1:0]  start_navg,
    input  logic [GAP_W-1:0]  gap,
    input  logic              cnv_valid,
    input  logic [DATA_W-1:0] cnv_data,
    output logic              cnv_req,
    output logic [CH_W-1:0]   cnv_chan,
    output logic              busy,
    output logic              sample_we,
    output logic [DATA_W-1:0] sample_data,
    output logic              done,
    output logic [DATA_W-1:0] avg_out
);

    localparam int MAX_SH = (1 << AVG_W) - 1;
    localparam int CNT_W  = MAX_SH + 1;
    localparam int ACC_W  = DATA_W + MAX_SH;

    seq_state_t state, nxt;

    logic [CH_W-1:0]  chan_q;
    logic [AVG_W-1:0] navg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic [GAP_W-1:0] gap_q;
    logic             last_smp;

    assign last_smp = (cnt_q == ((CNT_W'(1) << navg_q) - CNT_W'(1)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else if (abort) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_REQ;
            S_REQ:  nxt = S_WAIT;
            S_WAIT: begin
                if (cnv_valid) begin
                    if (last_smp)            nxt = S_DONE;
                    else if (gap == '0)      nxt = S_REQ;
                    else                     nxt = S_GAP;
                end
            end
            S_GAP:  if (gap_q >= gap) nxt = S_REQ;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnv_req     = (state == S_REQ);
        busy        = (state != S_IDLE);
        sample_we   = (state == S_WAIT) && cnv_valid;
        done        = (state == S_DONE);
        sample_data = cnv_data;
        cnv_chan    = chan_q;
        avg_out     = DATA_W'(acc_q >> navg_q);
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            navg_q <= '0;
            cnt_q  <= '0;
            acc_q  <= '0;
            gap_q  <= '0;
        end else begin
            if ((state == S_IDLE) && start && !abort) begin
                chan_q <= start_chan;
                navg_q <= start_navg;
                cnt_q  <= '0;
                acc_q  <= '0;
            end else if (sample_we) begin
                acc_q <= acc_q + ACC_W'(cnv_data);
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (state == S_WAIT) begin
                gap_q <= GAP_W'(1);
            end else if (state == S_GAP) begin
                gap_q <= gap_q + GAP_W'(1);
            end
        end
    end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int NUM_CH  = 8,
    parameter int AVG_W   = 4,
    parameter int CH_W    = 3,
    parameter int CLK_W   = 8,
    parameter int SR_W    = 16,
    parameter int CHCTL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] avg_in,
    input  logic              sample_we,
    input  logic [CH_W-1:0]   sample_chan,
    input  logic [DATA_W-1:0] sample_data,
    output logic              start,
    output logic              abort,
    output logic [CH_W-1:0]   start_chan,
    output logic [AVG_W-1:0]  start_navg,
    output logic [2*SR_W-1:0] gap,
    output logic              ctrl_en,
    output logic              vref_int,
    output logic [CLK_W-1:0]  clk_div,
    output logic              irq
);

    logic [CH_W-1:0]   chan_q;
    logic [AVG_W-1:0]  navg_q;
    logic              en_q;
    logic              vref_q;
    logic [CLK_W-1:0]  clk_q;
    logic [SR_W-1:0]   srlo_q;
    logic [SR_W-1:0]   srhi_q;
    logic [DATA_W-1:0] avg_q;
    logic              irq_q;

    logic [CHCTL_W-1:0] chctl_all [NUM_CH];
    logic [DATA_W-1:0]  data_all  [NUM_CH];

    logic ctrl_wr;
    logic avg_rd;

    assign ctrl_wr    = bus_wr && (bus_addr == A_CTRL);
    assign avg_rd     = bus_rd && (bus_addr == A_AVG);
    assign abort      = ctrl_wr && (bus_wdata == 32'd0);
    assign start      = ctrl_wr && !busy && bus_wdata[B_START] && bus_wdata[B_EN];
    assign start_chan = bus_wdata[CHAN_LSB +: CH_W];
    assign start_navg = bus_wdata[AVG_LSB +: AVG_W];
    assign gap        = {srhi_q, srlo_q};
    assign ctrl_en    = en_q;
    assign vref_int   = vref_q;
    assign clk_div    = clk_q;
    assign irq        = irq_q;

    // control word and global registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            navg_q <= '0;
            en_q   <= 1'b0;
            vref_q <= 1'b0;
            clk_q  <= '0;
            srlo_q <= '0;
            srhi_q <= '0;
        end else begin
            if (ctrl_wr && (abort || !busy)) begin
                chan_q <= bus_wdata[CHAN_LSB +: CH_W];
                navg_q <= bus_wdata[AVG_LSB +: AVG_W];
                en_q   <= bus_wdata[B_EN];
                vref_q <= bus_wdata[B_VREF];
            end
            if (bus_wr && (bus_addr == A_CLK))  clk_q  <= bus_wdata[CLK_W-1:0];
            if (bus_wr && (bus_addr == A_SRLO)) srlo_q <= bus_wdata[SR_W-1:0];
            if (bus_wr && (bus_addr == A_SRHI)) srhi_q <= bus_wdata[SR_W-1:0];
        end
    end

    // average result and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (done) begin
                avg_q <= avg_in;
            end
            if (done) begin
                irq_q <= 1'b1;
            end else if (avg_rd || abort) begin
                irq_q <= 1'b0;
            end
        end
    end

    // per-channel registers
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [CHCTL_W-1:0] ctl_q;
        logic [DATA_W-1:0]  dat_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q <= '0;
                dat_q <= '0;
            end else begin
                if (bus_wr && (bus_addr == ADDR_W'(int'(A_CHCTL) + i))) begin
                    ctl_q <= bus_wdata[CHCTL_W-1:0];
                end
                if (sample_we && (sample_chan == CH_W'(i))) begin
                    dat_q <= sample_data;
                end
            end
        end

        assign chctl_all[i] = ctl_q;
        assign data_all[i]  = dat_q;
    end

    // read mux
    always_comb begin
        bus_rdata = 32'd0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[CHAN_LSB +: CH_W] = chan_q;
                bus_rdata[B_EN]             = en_q;
                bus_rdata[AVG_LSB +: AVG_W] = navg_q;
                bus_rdata[B_VREF]           = vref_q;
                bus_rdata[B_BUSY]           = busy;
            end
            A_CLK:  bus_rdata[CLK_W-1:0]  = clk_q;
            A_SRLO: bus_rdata[SR_W-1:0]   = srlo_q;
            A_SRHI: bus_rdata[SR_W-1:0]   = srhi_q;
            A_AVG:  bus_rdata[DATA_W-1:0] = avg_q;
            default: begin
                for (int k = 0; k < NUM_CH; k++) begin
                    if (bus_addr == ADDR_W'(int'(A_CHCTL) + k)) begin
                        bus_rdata[CHCTL_W-1:0] = chctl_all[k];
                    end
                    if (bus_addr == ADDR_W'(int'(A_DATA) + k)) begin
                        bus_rdata[DATA_W-1:0] = data_all[k];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int NUM_CH  = 8,
    parameter int AVG_W   = 4,
    parameter int CLK_W   = 8,
    parameter int SR_W    = 16,
    parameter int CHCTL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              cnv_req,
    output logic [2:0]        cnv_chan,
    output logic              cnv_vref_int,
    output logic [7:0]        cnv_clk_div,
    input  logic              cnv_valid,
    input  logic [9:0]        cnv_data
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int GAP_W = 2 * SR_W;

    logic              start_w;
    logic              abort_w;
    logic [CH_W-1:0]   start_chan_w;
    logic [AVG_W-1:0]  start_navg_w;
    logic [GAP_W-1:0]  gap_w;
    logic              ctrl_en_w;
    logic              busy_w;
    logic              sample_we_w;
    logic [DATA_W-1:0] sample_data_w;
    logic              done_w;
    logic [DATA_W-1:0] avg_w;

    adc_seq_regs #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH),
        .AVG_W  (AVG_W),
        .CH_W   (CH_W),
        .CLK_W  (CLK_W),
        .SR_W   (SR_W),
        .CHCTL_W(CHCTL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy_w),
        .done       (done_w),
        .avg_in     (avg_w),
        .sample_we  (sample_we_w),
        .sample_chan(cnv_chan),
        .sample_data(sample_data_w),
        .start      (start_w),
        .abort      (abort_w),
        .start_chan (start_chan_w),
        .start_navg (start_navg_w),
        .gap        (gap_w),
        .ctrl_en    (ctrl_en_w),
        .vref_int   (cnv_vref_int),
        .clk_div    (cnv_clk_div),
        .irq        (irq)
    );

    adc_seq_fsm #(
        .DATA_W(DATA_W),
        .AVG_W (AVG_W),
        .CH_W  (CH_W),
        .GAP_W (GAP_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .abort      (abort_w),
        .start_chan (start_chan_w),
        .start_navg (start_navg_w),
        .gap        (gap_w),
        .cnv_valid  (cnv_valid),
        .cnv_data   (cnv_data),
        .cnv_req    (cnv_req),
        .cnv_chan   (cnv_chan),
        .busy       (busy_w),
        .sample_we  (sample_we_w),
        .sample_data(sample_data_w),
        .done       (done_w),
        .avg_out    (avg_w)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cnv_req,
    input logic        irq,
    input logic        done_pulse,
    input logic        busy,
    input logic        ctrl_en,
    input logic        bus_rd,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic [2:0]  cnv_chan
);

    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_req |=> !cnv_req);

    assert_result_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == A_AVG) || (bus_addr >= A_DATA)) |-> (bus_rdata[31:10] == 22'd0));

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_AVG) && !done_pulse) |=> !irq);

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done_pulse));

    assert_chan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cnv_chan));

    assert_req_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_req |-> ctrl_en);

endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_req   (cnv_req),
    .irq       (irq),
    .done_pulse(done_w),
    .busy      (busy_w),
    .ctrl_en   (ctrl_en_w),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cnv_chan  (cnv_chan)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        cnv_req;
    logic [2:0]  cnv_chan;
    logic        cnv_vref_int;
    logic [7:0]  cnv_clk_div;
    logic        cnv_valid = 1'b0;
    logic [9:0]  cnv_data = '0;

    adc_seq_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cnv_req(cnv_req), .cnv_chan(cnv_chan),
        .cnv_vref_int(cnv_vref_int), .cnv_clk_div(cnv_clk_div),
        .cnv_valid(cnv_valid), .cnv_data(cnv_data)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // converter model state
    int          req_cnt = 0;
    int          sum = 0;
    int          last_valid_cyc = -1;
    int          gap_meas = -1;
    int          last_sample = 0;
    int          irq_cyc = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter: samples 2 falling edges after a request
    initial begin
        int pend = 0;
        int lat = 0;
        forever begin
            @(negedge clk);
            if (cnv_valid) cnv_valid = 1'b0;
            if (cnv_req) begin
                req_cnt++;
                if (last_valid_cyc >= 0) gap_meas = cyc - last_valid_cyc;
                pend = 1;
                lat = 2;
            end else if (pend != 0) begin
                lat--;
                if (lat == 0) begin
                    cnv_data  = 10'($urandom % 1024);
                    cnv_valid = 1'b1;
                    sum += int'(cnv_data);
                    last_sample = int'(cnv_data);
                    last_valid_cyc = cyc;
                    pend = 0;
                end
            end
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output int d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq();
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        irq_cyc = cyc;
    endtask

    function automatic int ctrl_word(int ch, int n, int en, int vref);
        return (ch << 1) | (en << 4) | (n << 5) | (vref << 9);
    endfunction

    task automatic model_clear();
        req_cnt = 0; sum = 0; last_valid_cyc = -1; gap_meas = -1;
    endtask

    task automatic run_conv(input int ch, input int n, input int g, input int vref);
        int rd;
        bus_write(5'd2, 32'(g));
        bus_write(5'd3, 32'd0);
        model_clear();
        bus_write(5'd0, 32'(ctrl_word(ch, n, 1, vref) | 1));
        wait_irq();
        chk("R6 irq raised", int'(irq), 1);
        chk("R6 irq latency", irq_cyc - last_valid_cyc, 2);
        chk("R3 request count", req_cnt, 1 << n);
        if (n > 0) chk("R10 gap", gap_meas, g + 1);
        bus_read(5'(16 + ch), rd);
        chk("R5 data reg", rd, last_sample);
        bus_read(5'd0, rd);
        chk("R2 ctrl readback", rd, ctrl_word(ch, n, 1, vref));
        chk("R2 vref pin", int'(cnv_vref_int), vref);
        bus_read(5'd4, rd);
        chk("R3 average", rd, sum >> n);
        chk("R6 irq cleared by read", int'(irq), 0);
    endtask

    initial begin
        int rd;
        int d6;
        int rc;
        int unsigned seed;
        seed = $urandom(32'd1234);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 req", int'(cnv_req), 0);
        bus_read(5'd0, rd);  chk("R1 ctrl", rd, 0);
        bus_read(5'd4, rd);  chk("R1 avg", rd, 0);
        bus_read(5'd16, rd); chk("R1 data0", rd, 0);
        bus_read(5'd2, rd);  chk("R1 scan", rd, 0);

        // directed cases
        run_conv(3, 0, 0, 1);
        run_conv(7, 2, 5, 0);
        run_conv(0, 3, 0, 1);

        // R4: upper bits of results zero
        bus_read(5'd4, rd);  chk("R4 avg upper", rd >> 10, 0);
        bus_read(5'd23, rd); chk("R4 data upper", rd >> 10, 0);

        // random cases
        for (int i = 0; i < 10; i++) begin
            run_conv(int'($urandom % 8), int'($urandom % 4),
                     int'($urandom % 4), int'($urandom % 2));
        end

        // R7: start while busy ignored
        bus_read(5'd22, d6);
        bus_write(5'd2, 32'd4);
        model_clear();
        bus_write(5'd0, 32'(ctrl_word(1, 3, 1, 0) | 1));
        repeat (6) @(negedge clk);
        bus_write(5'd0, 32'(ctrl_word(6, 0, 1, 1) | 1));
        bus_read(5'd0, rd);
        chk("R7 ctrl unchanged while busy", rd & 32'h3FF, ctrl_word(1, 3, 1, 0));
        chk("R2 busy flag", (rd >> 10) & 1, 1);
        wait_irq();
        chk("R7 request count", req_cnt, 8);
        bus_read(5'd22, rd);
        chk("R7 other channel data", rd, d6);
        bus_read(5'd4, rd);
        chk("R7 average", rd, sum >> 3);

        // R8: start without enable
        model_clear();
        bus_write(5'd0, 32'(ctrl_word(5, 2, 0, 0) | 1));
        repeat (40) @(negedge clk);
        chk("R8 no request", req_cnt, 0);
        chk("R8 no irq", int'(irq), 0);
        bus_read(5'd0, rd);
        chk("R8 fields stored", rd, ctrl_word(5, 2, 0, 0));

        // R9: abort mid conversion
        bus_write(5'd2, 32'd10);
        model_clear();
        bus_write(5'd0, 32'(ctrl_word(2, 3, 1, 0) | 1));
        repeat (15) @(negedge clk);
        bus_write(5'd0, 32'd0);
        rc = req_cnt;
        repeat (60) @(negedge clk);
        chk("R9 no requests after abort", req_cnt, rc);
        chk("R9 no irq after abort", int'(irq), 0);
        bus_read(5'd0, rd);
        chk("R9 ctrl idle", rd, 0);

        // R9: zero control clears pending irq
        bus_write(5'd2, 32'd0);
        model_clear();
        bus_write(5'd0, 32'(ctrl_word(4, 0, 1, 0) | 1));
        wait_irq();
        chk("R9 irq pending", int'(irq), 1);
        bus_write(5'd0, 32'd0);
        chk("R9 irq cleared by zero write", int'(irq), 0);

        // R9: other registers accept and read back zero
        bus_write(5'd1, 32'hA5);
        bus_read(5'd1, rd); chk("R9 clk reg", rd, 32'hA5);
        chk("R9 clk pin", int'(cnv_clk_div), 32'hA5);
        bus_write(5'd3, 32'h1234);
        bus_read(5'd3, rd); chk("R9 scan hi", rd, 32'h1234);
        bus_write(5'd1, 32'd0);
        bus_write(5'd3, 32'd0);
        bus_read(5'd1, rd); chk("R9 clk zero", rd, 0);
        bus_read(5'd3, rd); chk("R9 scan hi zero", rd, 0);
        for (int c = 0; c < 8; c++) bus_write(5'(8 + c), 32'(c * 257 + 1));
        for (int c = 0; c < 8; c++) begin
            bus_read(5'(8 + c), rd); chk("R9 chctl", rd, c * 257 + 1);
        end
        for (int c = 0; c < 8; c++) bus_write(5'(8 + c), 32'd0);
        for (int c = 0; c < 8; c++) begin
            bus_read(5'(8 + c), rd); chk("R9 chctl zero", rd, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(1_900_000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule